// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Guard for One Half-Bridge

This block protects one half-bridge output of a PWM power stage. It receives the flag of an analog overcurrent comparator, a strobe that marks the start of each PWM frame, the commanded drive level and an already-decoded selection code. From these it produces the gate drive that is actually applied, a high-impedance enable and fault status. Each half-bridge on a chip gets its own instance, so an overcurrent on one output never touches another.

In cycle-by-cycle mode, an overcurrent event inverts the output until the next frame begins. A leaky overload counter rises once per frame that saw an event and falls once per clean frame. When it fills, the output is shut down. In latched mode, the first event shuts the output down at once. A shutdown holds until a reset request arrives. The selection code also picks one of four comparator thresholds, which the block passes to the analog side.

All pins are plain control and status signals, because the block has no data stream. There is no valid/ready handshake and no back-pressure. Every input is sampled on each clock.

Top module: `ocp_halfbridge_guard`

## Requirements
- R1: `thr_sel` follows `sel_code` combinationally. Codes 0..3 select cycle-by-cycle mode with `thr_sel` = code[1:0]. Codes 4..7 select latched mode with `thr_sel` = code[1:0]. Codes 8..15 are out of range and select latched mode with `thr_sel` = 0, the lowest threshold.
- R2: `oc_raw` passes through a two-flop synchronizer. A level sampled high at a rising edge first changes `gate_drive`, `hiz_en` or `limit_pulse` after the second rising edge that follows.
- R3: In cycle-by-cycle mode, an overcurrent event makes `gate_drive` the inverse of `pwm_drive`. The inversion lasts until the clock edge that samples `frame_start` high, after which normal drive resumes.
- R4: In cycle-by-cycle mode, at each `frame_start` the 4-bit `ovl_count` rises by one if the ending frame saw any event. Several events in one frame count once, and the counter saturates at 15.
- R5: At a `frame_start` that ends a frame without events, `ovl_count` falls by one and saturates at 0. Between frame starts it holds its value.
- R6: When `ovl_count` reaches 15, `hiz_en` and `fault_flag` go high on the same edge, and `gate_drive` is forced to 0.
- R7: In latched mode, the first event raises `hiz_en` and `fault_flag`. There is no inversion and no `limit_pulse`, and `ovl_count` stays unchanged.
- R8: While `hiz_en` is high, `gate_drive` is 0, overcurrent events are ignored (no inversion, no pulse, no count) and the counter is frozen. The fault is sticky.
- R9: A high `rst_req` at a clock edge clears the fault, the counter and any active inversion. An active-low `rst_n` does the same asynchronously.
- R10: `limit_pulse` is high for one cycle when an inversion starts. It is not repeated for further events within the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_raw | input | 1 | Asynchronous overcurrent comparator flag |
| frame_start | input | 1 | One-cycle strobe at the start of each PWM frame |
| pwm_drive | input | 1 | Commanded half-bridge level |
| sel_code | input | 4 | Decoded selection: mode and threshold |
| rst_req | input | 1 | Synchronous fault reset request |
| gate_drive | output | 1 | Effective gate drive |
| hiz_en | output | 1 | High-impedance enable for the output stage |
| fault_flag | output | 1 | Sticky shutdown flag |
| ovl_count | output | 4 | Overload counter value |
| limit_pulse | output | 1 | One-cycle pulse per started limiting event |
| thr_sel | output | 2 | Threshold level for the comparator, 0 lowest |

## Verification
The bound checker watches a set of invariants on every cycle:
- the gate is held low in high impedance;
- a full counter always means a fault;
- the fault stays set until a reset request;
- the counter changes only at frame starts and by at most one step;
- there is no pulse in latched mode;
- out-of-range codes map to the lowest threshold.

Other properties can only be shown by the bench's frame scenarios:
- the exact three-edge latency through the synchronizer;
- the inversion against `pwm_drive` and its release at the next frame;
- a burst of events counting once;
- saturation at zero;
- reaching the shutdown after fifteen faulty frames;
- events being ignored after shutdown.

// File: rtl/ocp_guard_pkg.sv
`timescale 1ns/1ps
package ocp_guard_pkg;
  typedef enum logic {
    MODE_CYCLE = 1'b0,
    MODE_LATCH = 1'b1
  } prot_mode_e;
endpackage

// File: rtl/ocp_sync.sv
`timescale 1ns/1ps
module ocp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[0] <= 1'b0;
        else        sr[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[g] <= 1'b0;
        else        sr[g] <= sr[g-1];
      end
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/ocp_sel_decode.sv
`timescale 1ns/1ps
module ocp_sel_decode
  import ocp_guard_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int LVL_W  = 2
) (
  input  logic [CODE_W-1:0] code,
  output prot_mode_e        mode,
  output logic [LVL_W-1:0]  level
);
  localparam int NUM_LVL = 1 << LVL_W;
  localparam logic [CODE_W-1:0] CYC_END = CODE_W'(NUM_LVL);
  localparam logic [CODE_W-1:0] LAT_END = CODE_W'(2 * NUM_LVL);

  always_comb begin
    if (code < CYC_END) begin
      mode  = MODE_CYCLE;
      level = code[LVL_W-1:0];
    end else if (code < LAT_END) begin
      mode  = MODE_LATCH;
      level = code[LVL_W-1:0];
    end else begin
      mode  = MODE_LATCH;
      level = '0;
    end
  end
endmodule

// File: rtl/ocp_overload_ctr.sv
`timescale 1ns/1ps
module ocp_overload_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             up,
  output logic [CNT_W-1:0] cnt,
  output logic             reach_max
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (step) begin
      if (up) cnt_q <= (cnt_q == CMAX) ? CMAX : cnt_q + ONE;
      else    cnt_q <= (cnt_q == '0)   ? '0   : cnt_q - ONE;
    end
  end

  assign reach_max = !clr && step && up && (cnt_q == CMAX - ONE);
  assign cnt       = cnt_q;
endmodule

// File: rtl/ocp_halfbridge_guard.sv
`timescale 1ns/1ps
module ocp_halfbridge_guard
  import ocp_guard_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int CODE_W      = 4,
  parameter int LVL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oc_raw,
  input  logic              frame_start,
  input  logic              pwm_drive,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              rst_req,
  output logic              gate_drive,
  output logic              hiz_en,
  output logic              fault_flag,
  output logic [CNT_W-1:0]  ovl_count,
  output logic              limit_pulse,
  output logic [LVL_W-1:0]  thr_sel
);
  logic       oc_s;
  prot_mode_e mode_w;
  logic       cyc_mode;
  logic       oc_evt;
  logic       ctr_step;
  logic       reach_max;
  logic       fault_q;
  logic       flip_q;
  logic       hit_q;
  logic       pulse_q;

  ocp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (oc_raw),
    .q     (oc_s)
  );

  ocp_sel_decode #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_dec (
    .code  (sel_code),
    .mode  (mode_w),
    .level (thr_sel)
  );

  assign cyc_mode = (mode_w == MODE_CYCLE);
  assign oc_evt   = oc_s && !fault_q;
  assign ctr_step = frame_start && cyc_mode && !fault_q;

  ocp_overload_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rst_req),
    .step      (ctr_step),
    .up        (hit_q),
    .cnt       (ovl_count),
    .reach_max (reach_max)
  );

  // sticky shutdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                fault_q <= 1'b0;
    else if (rst_req)                          fault_q <= 1'b0;
    else if (reach_max || (oc_evt && !cyc_mode)) fault_q <= 1'b1;
  end

  // per-frame event memory; an event in the strobe cycle belongs to the new frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hit_q <= 1'b0;
    else if (rst_req)     hit_q <= 1'b0;
    else if (frame_start) hit_q <= oc_evt && cyc_mode;
    else if (oc_evt && cyc_mode) hit_q <= 1'b1;
  end

  // forced inversion, released by the next frame strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flip_q <= 1'b0;
    else if (rst_req)     flip_q <= 1'b0;
    else if (frame_start) flip_q <= oc_evt && cyc_mode;
    else if (oc_evt && cyc_mode) flip_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pulse_q <= 1'b0;
    else if (rst_req) pulse_q <= 1'b0;
    else              pulse_q <= oc_evt && cyc_mode && (!flip_q || frame_start);
  end

  assign gate_drive  = fault_q ? 1'b0 : (pwm_drive ^ flip_q);
  assign hiz_en      = fault_q;
  assign fault_flag  = fault_q;
  assign limit_pulse = pulse_q;
endmodule

// File: rtl/ocp_guard_checker.sv
`timescale 1ns/1ps
module ocp_guard_checker #(
  parameter int CNT_W  = 4,
  parameter int CODE_W = 4,
  parameter int LVL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic [CODE_W-1:0] sel_code,
  input logic              rst_req,
  input logic              gate_drive,
  input logic              hiz_en,
  input logic              fault_flag,
  input logic [CNT_W-1:0]  ovl_count,
  input logic              limit_pulse,
  input logic [LVL_W-1:0]  thr_sel
);
  localparam int NUM_LVL = 1 << LVL_W;
  localparam logic [CODE_W-1:0] LAT_BEG = CODE_W'(NUM_LVL);
  localparam logic [CODE_W-1:0] OOR_BEG = CODE_W'(2 * NUM_LVL);
  localparam logic [CNT_W-1:0]  CMAX    = '1;
  localparam logic [CNT_W-1:0]  ONE     = CNT_W'(1);

  logic code_latched;
  assign code_latched = (sel_code >= LAT_BEG);

  a_r1_oor_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_code >= OOR_BEG) |-> (thr_sel == '0));

  a_r6_full_means_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_count == CMAX) |-> (hiz_en && fault_flag));

  a_r8_hiz_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_en |-> !gate_drive);

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !rst_req) |=> fault_flag);

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!fault_flag && ovl_count == '0 && !limit_pulse));

  a_r5_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !rst_req) |=> $stable(ovl_count));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !rst_req) |=> (ovl_count == $past(ovl_count) ||
                                   ovl_count == $past(ovl_count) + ONE ||
                                   ovl_count == $past(ovl_count) - ONE));

  a_r7_no_pulse_latched: assert property (@(posedge clk) disable iff (!rst_n)
    code_latched |=> !limit_pulse);

  a_r10_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    limit_pulse |=> (!limit_pulse || $past(frame_start)));
endmodule

bind ocp_halfbridge_guard ocp_guard_checker #(
  .CNT_W  (CNT_W),
  .CODE_W (CODE_W),
  .LVL_W  (LVL_W)
) u_guard_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .sel_code    (sel_code),
  .rst_req     (rst_req),
  .gate_drive  (gate_drive),
  .hiz_en      (hiz_en),
  .fault_flag  (fault_flag),
  .ovl_count   (ovl_count),
  .limit_pulse (limit_pulse),
  .thr_sel     (thr_sel)
);

// File: tb/test_ocp_halfbridge_guard.sv
`timescale 1ns/1ps
module test_ocp_halfbridge_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oc_raw = 1'b0;
  logic       frame_start = 1'b0;
  logic       pwm_drive = 1'b1;
  logic [3:0] sel_code = 4'd0;
  logic       rst_req = 1'b0;
  logic       gate_drive, hiz_en, fault_flag, limit_pulse;
  logic [3:0] ovl_count;
  logic [1:0] thr_sel;

  ocp_halfbridge_guard i_ocp_halfbridge_guard (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .frame_start(frame_start),
    .pwm_drive(pwm_drive), .sel_code(sel_code), .rst_req(rst_req),
    .gate_drive(gate_drive), .hiz_en(hiz_en), .fault_flag(fault_flag),
    .ovl_count(ovl_count), .limit_pulse(limit_pulse), .thr_sel(thr_sel)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // scoreboard: expected {pulse, hiz, fault, gate, count}
  string      q_tag[$];
  logic [7:0] q_exp[$];

  // expected state, kept from the requirements
  int e_cnt;
  bit e_fault, prev_hit, prev_flip, cyc, pwm;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input string tag, input bit p, input bit f, input bit g, input int c);
    q_tag.push_back(tag);
    q_exp.push_back({p, f, f, g, 4'(c)});
  endtask

  // monitor: samples 12 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #12;
      while (q_tag.size() > 0) begin
        string      t;
        logic [7:0] e;
        t = q_tag.pop_front();
        e = q_exp.pop_front();
        chk(t, {limit_pulse, hiz_en, fault_flag, gate_drive, ovl_count}, e);
      end
    end
  end

  // one PWM frame of 8 cycles; hits: 0 none, 1 single event, 2 burst
  task automatic frame(input int hits, input string tag);
    bit cur_flip = 1'b0;
    bit cur_hit  = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bit p = 1'b0;
      bit fl;
      @(posedge clk);
      #2;
      frame_start = (i == 0);
      oc_raw      = (hits == 1 && i == 1) || (hits == 2 && i >= 1 && i <= 3);
      pwm_drive   = pwm;
      if (i == 1) begin
        if (cyc && !e_fault) begin
          if (prev_hit) e_cnt = (e_cnt < 15) ? e_cnt + 1 : 15;
          else          e_cnt = (e_cnt > 0) ? e_cnt - 1 : 0;
          if (e_cnt == 15) e_fault = 1'b1;
        end
      end
      if (i == 4 && hits != 0 && !e_fault) begin
        if (cyc) begin cur_flip = 1'b1; cur_hit = 1'b1; p = 1'b1; end
        else     e_fault = 1'b1;
      end
      fl = (i == 0) ? prev_flip : cur_flip;
      push(tag, p, e_fault, e_fault ? 1'b0 : (pwm ^ fl), e_cnt);
    end
    prev_hit  = cur_hit;
    prev_flip = cur_flip;
  endtask

  task automatic fault_reset(input string tag);
    @(posedge clk);
    #2;
    frame_start = 1'b0; oc_raw = 1'b0; rst_req = 1'b1;
    push(tag, 1'b0, e_fault, e_fault ? 1'b0 : (pwm ^ prev_flip), e_cnt);
    @(posedge clk);
    #2;
    rst_req = 1'b0;
    e_fault = 1'b0; e_cnt = 0; prev_hit = 1'b0; prev_flip = 1'b0;
    push(tag, 1'b0, 1'b0, pwm, 0);
  endtask

  task automatic thr_check(input logic [3:0] code, input logic [1:0] exp);
    sel_code = code;
    #1;
    chk("R1 threshold decode", {6'd0, thr_sel}, {6'd0, exp});
  endtask

  initial begin
    e_cnt = 0; e_fault = 1'b0; prev_hit = 1'b0; prev_flip = 1'b0; cyc = 1'b1; pwm = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk);
    #12;
    chk("reset state", {limit_pulse, hiz_en, fault_flag, gate_drive, ovl_count}, 8'b0001_0000);

    // R1: code 0..3 cycle, 4..7 latched, 8..15 lowest threshold
    thr_check(4'd0, 2'd0);
    thr_check(4'd3, 2'd3);
    thr_check(4'd5, 2'd1);
    thr_check(4'd7, 2'd3);
    thr_check(4'd9, 2'd0);
    thr_check(4'd15, 2'd0);
    sel_code = 4'd2;

    // R2, R3, R10: single event inverts, pulses once, latency three edges
    frame(1, "R2 R3 R10 single event");
    frame(0, "R4 count after event frame");
    frame(2, "R10 R4 burst counts once");
    frame(0, "R4 burst increments by one");
    frame(0, "R5 decrement");
    frame(0, "R5 saturate at zero");
    pwm = 1'b0;
    frame(1, "R3 inversion with low drive");
    pwm = 1'b1;
    for (int k = 0; k < 16; k++) frame(1, "R6 climb to shutdown");
    frame(0, "R6 shutdown at fifteen");
    frame(1, "R8 events ignored in hiz");
    frame(0, "R8 frozen counter");
    fault_reset("R9 reset request clears");

    // R7: latched mode
    sel_code = 4'd5;
    cyc = 1'b0;
    frame(0, "R7 latched idle");
    frame(1, "R7 latched first event");
    frame(0, "R7 latched holds");
    fault_reset("R9 reset after latch");

    // out-of-range code behaves as latched
    sel_code = 4'd12;
    frame(1, "R1 out of range is latched");
    fault_reset("R9 final reset");
    frame(0, "R9 clean after reset");

    repeat (3) @(posedge clk);
    #15;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule